// File: doc/BRIEF.md
# Track Segment Capture Monitor

The block sits beside a trigger segment finder that presents a whole array of `N_SEG` candidate segments in parallel on every clock. Each segment arrives as a packed record with a layer count, a pattern number, a strip position and a partition index. A segment is valid when its layer count is non-zero. Once software-side control arms the monitor, the block waits for the first clock in which any segment in the array is valid. On that clock it freezes the complete array, valid and invalid slots alike, into snapshot registers. It then holds the snapshot until it is armed again.

Next to the snapshot the block keeps a saturating count of clock cycles that held at least one valid segment. It also marks captured records whose contents lie outside the legal range: a layer count of seven, or a strip beyond 191. A read index picks one stored segment, and its unpacked fields appear on the read port one clock later. Field widths live in a shared package, so that later record fields only widen the packed record.

Top module: `seg_capture_mon`

## Requirements
- R1: While reset is high, and on the first sampling after it is released, `armed_o`, `captured_o`, `err_any_o`, `hit_count_o` and every read-port output are zero.
- R2: Input slot i occupies bits [i*19 +: 19] of `seg_bus_i`. Inside a slot, layer count is bits [18:16], pattern number [15:12], strip [11:4] and partition [3:0]. The 4-bit pattern number is presented zero-extended to 5 bits on `rd_pid_o`.
- R3: A slot is valid exactly when its layer count is non-zero. When `armed_o` is high and some slot is valid at a clock edge with `arm_i` low, the whole array is stored at that edge. After the edge `captured_o` is 1 and `armed_o` is 0. `armed_o` and `captured_o` are never both high.
- R4: While captured, later frames leave the stored array and `captured_o` unchanged until `arm_i` is asserted.
- R5: `arm_i` high at an edge sets `armed_o`, clears `captured_o` and clears `hit_count_o`. It takes priority over a valid frame in the same cycle, which is then neither stored nor counted. Re-arming does not erase the stored array.
- R6: `hit_count_o` grows by one for every edge where `arm_i` is low and at least one slot is valid, whether or not the block is armed. It stops at 65535.
- R7: The read port shows the stored fields of slot `rd_idx_i` from the edge after `rd_idx_i` is applied. Before that edge it keeps its previous value.
- R8: `rd_err_o` is 1 for a stored slot whose layer count is non-zero and either equals 7 or has a strip above 191. Such a slot is still stored. A slot with layer count 0 never raises an error. `err_any_o` is 1 exactly while `captured_o` is 1 and some stored slot has its error set.
- R9: Stored slots with layer count 0 keep their pattern, strip and partition values as presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm the monitor and clear the hit count |
| seg_bus_i | input | N_SEG*19 | Packed segment records from the finder |
| rd_idx_i | input | IDX_W | Stored slot to read |
| armed_o | output | 1 | Waiting for a valid frame |
| captured_o | output | 1 | Snapshot holds a captured frame |
| err_any_o | output | 1 | Captured frame contains an out-of-range record |
| hit_count_o | output | 16 | Saturating count of cycles with a valid segment |
| rd_lc_o | output | 3 | Layer count of the selected slot |
| rd_pid_o | output | 5 | Pattern number of the selected slot |
| rd_strip_o | output | 8 | Strip of the selected slot |
| rd_part_o | output | 4 | Partition of the selected slot |
| rd_err_o | output | 1 | Error mark of the selected slot |

## Verification
Every state result (`armed_o`, `captured_o`, `hit_count_o`, `err_any_o`) is due at the edge that samples the frame or arm pulse. The read port is due one edge after `rd_idx_i` changes. The bench drives at the falling edge, advances a cycle model at the rising edge and compares at the next falling edge. It also compares the read port right after a new index is driven, which confirms the extra register stage of R7. The sweep runs every layer count against boundary strips in every slot, and a long run of valid frames takes the counter into saturation.

// File: rtl/seg_mon_pkg.sv
package seg_mon_pkg;

    localparam int LC_W      = 3;
    localparam int PID_IN_W  = 4;
    localparam int PID_W     = 5;
    localparam int STRIP_W   = 8;
    localparam int PART_W    = 4;
    localparam int IN_REC_W  = LC_W + PID_IN_W + STRIP_W + PART_W;
    localparam int REC_W     = LC_W + PID_W + STRIP_W + PART_W;
    localparam int STRIP_MAX = 191;
    localparam int LC_BAD    = 7;

    typedef struct packed {
        logic [LC_W-1:0]    lc;
        logic [PID_W-1:0]   pid;
        logic [STRIP_W-1:0] strip;
        logic [PART_W-1:0]  part;
    } seg_rec_t;

    typedef struct packed {
        logic valid;
        logic err;
    } seg_flag_t;

    function automatic seg_rec_t unpack_input(input logic [IN_REC_W-1:0] raw);
        seg_rec_t r;
        r.lc    = raw[IN_REC_W-1 -: LC_W];
        r.pid   = {{(PID_W-PID_IN_W){1'b0}}, raw[PART_W+STRIP_W +: PID_IN_W]};
        r.strip = raw[PART_W +: STRIP_W];
        r.part  = raw[PART_W-1:0];
        return r;
    endfunction

    function automatic logic [REC_W-1:0] rec_to_bits(input seg_rec_t r);
        return r;
    endfunction

    function automatic seg_rec_t bits_to_rec(input logic [REC_W-1:0] b);
        return seg_rec_t'(b);
    endfunction

    function automatic seg_flag_t classify(input seg_rec_t r);
        seg_flag_t f;
        f.valid = (r.lc != '0);
        f.err   = f.valid &&
                  ((r.lc == LC_W'(LC_BAD)) || (r.strip > STRIP_W'(STRIP_MAX)));
        return f;
    endfunction

endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import seg_mon_pkg::*;
#(
    parameter int N_SEG = 4
) (
    input  logic [N_SEG*IN_REC_W-1:0] seg_bus_i,
    output logic [N_SEG*REC_W-1:0]    rec_flat_o,
    output logic [N_SEG-1:0]          valid_o,
    output logic [N_SEG-1:0]          err_o
);

    for (genvar g = 0; g < N_SEG; g++) begin : g_slot
        seg_rec_t  rec;
        seg_flag_t flg;

        always_comb begin
            rec = unpack_input(seg_bus_i[g*IN_REC_W +: IN_REC_W]);
            flg = classify(rec);
        end

        assign rec_flat_o[g*REC_W +: REC_W] = rec_to_bits(rec);
        assign valid_o[g] = flg.valid;
        assign err_o[g]   = flg.err;
    end

endmodule

// File: rtl/seg_hit_counter.sv
module seg_hit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            count_o <= '0;
        end else if (hit_i && (count_o != CNT_TOP)) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/seg_snapshot.sv
module seg_snapshot
    import seg_mon_pkg::*;
#(
    parameter int N_SEG = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   arm_i,
    input  logic                   any_valid_i,
    input  logic [N_SEG*REC_W-1:0] rec_flat_i,
    input  logic [N_SEG-1:0]       err_i,
    output logic                   armed_o,
    output logic                   captured_o,
    output logic [N_SEG*REC_W-1:0] snap_flat_o,
    output logic [N_SEG-1:0]       snap_err_o
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } mon_state_t;

    mon_state_t state_q;
    logic       take;

    assign take = (state_q == ST_ARMED) && any_valid_i && !arm_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (arm_i) begin
            state_q <= ST_ARMED;
        end else if (take) begin
            state_q <= ST_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_flat_o <= '0;
            snap_err_o  <= '0;
        end else if (take) begin
            snap_flat_o <= rec_flat_i;
            snap_err_o  <= err_i;
        end
    end

    assign armed_o    = (state_q == ST_ARMED);
    assign captured_o = (state_q == ST_HELD);

endmodule

// File: rtl/seg_readback.sv
module seg_readback
    import seg_mon_pkg::*;
#(
    parameter int N_SEG = 4,
    parameter int IDX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_idx_i,
    input  logic [N_SEG*REC_W-1:0] snap_flat_i,
    input  logic [N_SEG-1:0]       snap_err_i,
    output seg_rec_t               rd_rec_o,
    output logic                   rd_err_o
);

    seg_rec_t sel_rec;
    logic     sel_err;

    always_comb begin
        sel_rec = '0;
        sel_err = 1'b0;
        for (int i = 0; i < N_SEG; i++) begin
            if (int'(rd_idx_i) == i) begin
                sel_rec = bits_to_rec(snap_flat_i[i*REC_W +: REC_W]);
                sel_err = snap_err_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_rec_o <= '0;
            rd_err_o <= 1'b0;
        end else begin
            rd_rec_o <= sel_rec;
            rd_err_o <= sel_err;
        end
    end

endmodule

// File: rtl/seg_capture_mon.sv
module seg_capture_mon
    import seg_mon_pkg::*;
#(
    parameter int N_SEG = 4,
    parameter int CNT_W = 16,
    parameter int IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arm_i,
    input  logic [N_SEG*IN_REC_W-1:0] seg_bus_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic                      armed_o,
    output logic                      captured_o,
    output logic                      err_any_o,
    output logic [CNT_W-1:0]          hit_count_o,
    output logic [LC_W-1:0]           rd_lc_o,
    output logic [PID_W-1:0]          rd_pid_o,
    output logic [STRIP_W-1:0]        rd_strip_o,
    output logic [PART_W-1:0]         rd_part_o,
    output logic                      rd_err_o
);

    logic [N_SEG*REC_W-1:0] rec_flat;
    logic [N_SEG-1:0]       slot_valid;
    logic [N_SEG-1:0]       slot_err;
    logic                   any_valid;
    logic [N_SEG*REC_W-1:0] snap_flat;
    logic [N_SEG-1:0]       snap_err;
    seg_rec_t               rd_rec;

    seg_decode #(.N_SEG(N_SEG)) u_decode (
        .seg_bus_i  (seg_bus_i),
        .rec_flat_o (rec_flat),
        .valid_o    (slot_valid),
        .err_o      (slot_err)
    );

    assign any_valid = |slot_valid;

    seg_hit_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (arm_i),
        .hit_i   (any_valid),
        .count_o (hit_count_o)
    );

    seg_snapshot #(.N_SEG(N_SEG)) u_snap (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .any_valid_i (any_valid),
        .rec_flat_i  (rec_flat),
        .err_i       (slot_err),
        .armed_o     (armed_o),
        .captured_o  (captured_o),
        .snap_flat_o (snap_flat),
        .snap_err_o  (snap_err)
    );

    assign err_any_o = captured_o && (|snap_err);

    seg_readback #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_read (
        .clk         (clk),
        .rst         (rst),
        .rd_idx_i    (rd_idx_i),
        .snap_flat_i (snap_flat),
        .snap_err_i  (snap_err),
        .rd_rec_o    (rd_rec),
        .rd_err_o    (rd_err_o)
    );

    assign rd_lc_o    = rd_rec.lc;
    assign rd_pid_o   = rd_rec.pid;
    assign rd_strip_o = rd_rec.strip;
    assign rd_part_o  = rd_rec.part;

endmodule

// File: rtl/seg_capture_mon_chk.sv
module seg_capture_mon_chk #(
    parameter int N_SEG = 4,
    parameter int REC_W = 20,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   arm_i,
    input logic                   armed_o,
    input logic                   captured_o,
    input logic                   err_any_o,
    input logic [CNT_W-1:0]       hit_count_o,
    input logic [N_SEG*REC_W-1:0] snap_flat
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    assert_state_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(armed_o && captured_o));

    assert_sticky_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (captured_o && !arm_i) |=> captured_o);

    assert_snap_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (captured_o && !arm_i) |=> $stable(snap_flat));

    assert_arm_effect_R5: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !captured_o && (hit_count_o == '0)));

    assert_count_sat_R6: assert property (@(posedge clk) disable iff (rst)
        ((hit_count_o == CNT_TOP) && !arm_i) |=> (hit_count_o == CNT_TOP));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> ((hit_count_o == $past(hit_count_o)) ||
                    (hit_count_o == $past(hit_count_o) + 1'b1)));

    assert_err_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !captured_o |-> !err_any_o);

endmodule

bind seg_capture_mon seg_capture_mon_chk #(
    .N_SEG(N_SEG),
    .REC_W(seg_mon_pkg::REC_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .armed_o     (armed_o),
    .captured_o  (captured_o),
    .err_any_o   (err_any_o),
    .hit_count_o (hit_count_o),
    .snap_flat   (snap_flat)
);

// File: tb/seg_capture_mon_tb.sv
module seg_capture_mon_tb;

    localparam int N   = 4;
    localparam int IRW = 19;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm_i = 1'b0;
    logic [N*IRW-1:0] seg_bus_i;
    logic [1:0]       rd_idx_i = '0;
    logic             armed_o, captured_o, err_any_o, rd_err_o;
    logic [15:0]      hit_count_o;
    logic [2:0]       rd_lc_o;
    logic [4:0]       rd_pid_o;
    logic [7:0]       rd_strip_o;
    logic [3:0]       rd_part_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // stimulus fields
    int c_lc[N], c_pid[N], c_strip[N], c_part[N];
    // model state
    int m_armed, m_cap, m_cnt;
    int s_lc[N], s_pid[N], s_strip[N], s_part[N];
    int r_lc, r_pid, r_strip, r_part, r_err;

    seg_capture_mon u_dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .seg_bus_i(seg_bus_i),
        .rd_idx_i(rd_idx_i), .armed_o(armed_o), .captured_o(captured_o),
        .err_any_o(err_any_o), .hit_count_o(hit_count_o), .rd_lc_o(rd_lc_o),
        .rd_pid_o(rd_pid_o), .rd_strip_o(rd_strip_o), .rd_part_o(rd_part_o),
        .rd_err_o(rd_err_o)
    );

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++)
            seg_bus_i[i*IRW +: IRW] = {c_lc[i][2:0], c_pid[i][3:0], c_strip[i][7:0], c_part[i][3:0]};
    end

    function automatic int is_err(int lc, int strip);
        return (lc != 0 && (lc == 7 || strip > 191)) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        int any;
        @(posedge clk);
        cycles++;
        any = 0;
        for (int i = 0; i < N; i++) if (c_lc[i] != 0) any = 1;
        if (rst) begin
            m_armed = 0; m_cap = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) begin
                s_lc[i] = 0; s_pid[i] = 0; s_strip[i] = 0; s_part[i] = 0;
            end
            r_lc = 0; r_pid = 0; r_strip = 0; r_part = 0; r_err = 0;
        end else begin
            r_lc = s_lc[rd_idx_i]; r_pid = s_pid[rd_idx_i];
            r_strip = s_strip[rd_idx_i]; r_part = s_part[rd_idx_i];
            r_err = is_err(r_lc, r_strip);
            if (arm_i) begin
                m_armed = 1; m_cap = 0; m_cnt = 0;
            end else begin
                if (m_armed == 1 && any == 1) begin
                    m_armed = 0; m_cap = 1;
                    for (int i = 0; i < N; i++) begin
                        s_lc[i] = c_lc[i]; s_pid[i] = c_pid[i];
                        s_strip[i] = c_strip[i]; s_part[i] = c_part[i];
                    end
                end
                if (any == 1 && m_cnt < 65535) m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic chk_state(string req);
        int e;
        e = 0;
        for (int i = 0; i < N; i++) if (is_err(s_lc[i], s_strip[i]) == 1) e = 1;
        chk(req, "armed", int'(armed_o), m_armed);
        chk(req, "captured", int'(captured_o), m_cap);
        chk(req, "count", int'(hit_count_o), m_cnt);
        chk("R8", "err_any", int'(err_any_o), m_cap & e);
    endtask

    task automatic chk_read(string req);
        chk(req, "rd_lc", int'(rd_lc_o), r_lc);
        chk(req, "rd_pid", int'(rd_pid_o), r_pid);
        chk(req, "rd_strip", int'(rd_strip_o), r_strip);
        chk(req, "rd_part", int'(rd_part_o), r_part);
        chk("R8", "rd_err", int'(rd_err_o), r_err);
    endtask

    task automatic read_all();
        for (int k = 0; k < N; k++) begin
            rd_idx_i = 2'(k);
            #1 chk_read("R7");
            step();
            chk_read("R2");
        end
    endtask

    task automatic set_idle_frame();
        for (int i = 0; i < N; i++) begin
            c_lc[i] = 0; c_pid[i] = 9 + i; c_strip[i] = 200 + i; c_part[i] = 15 - i;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        set_idle_frame();
        @(negedge clk);
        step(); step();
        chk_state("R1");
        chk_read("R1");
        rst = 1'b0;
        step();
        chk_state("R1");
        chk_read("R1");

        // sweep: slot x layer count x strip boundary
        for (int s = 0; s < N; s++) begin
            for (int lc = 0; lc < 8; lc++) begin
                for (int sv = 0; sv < 4; sv++) begin
                    int strips[4];
                    strips = '{0, 191, 192, 255};
                    set_idle_frame();
                    arm_i = 1'b1;
                    step();
                    arm_i = 1'b0;
                    chk_state("R5");
                    c_lc[s] = lc; c_pid[s] = (s * 5 + lc) % 16;
                    c_strip[s] = strips[sv]; c_part[s] = (lc + 3 * s) % 16;
                    step();
                    chk_state("R3");
                    for (int i = 0; i < N; i++) begin
                        c_lc[i] = 3; c_pid[i] = 15; c_strip[i] = 10 + i; c_part[i] = i;
                    end
                    step();
                    chk_state("R4");
                    read_all();
                    chk_state("R9");
                end
            end
        end

        // arm together with a valid frame: arm wins
        for (int i = 0; i < N; i++) c_lc[i] = 2;
        arm_i = 1'b1;
        step();
        arm_i = 1'b0;
        chk_state("R5");
        set_idle_frame();
        step();
        chk_state("R5");
        read_all();

        // saturation
        arm_i = 1'b1;
        step();
        arm_i = 1'b0;
        c_lc[2] = 1; c_strip[2] = 5;
        for (int k = 0; k < 65540; k++) step();
        chk_state("R6");
        set_idle_frame();
        step();
        chk_state("R6");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule